// File: doc/BRIEF.md
# PCI Configuration Address/Data Port Decoder

This block sits in a host bridge and turns host I/O cycles into PCI configuration requests using the classic two-port indirect scheme. Software first writes a 32-bit index word to an index port. The word holds an enable flag, a bus number, a device/function number and a dword-aligned register offset. Software then reads or writes a four-byte data window. Each data-window access that passes the enable check becomes a single-cycle request on a device-select interface. The request carries bus, device/function, byte register offset, byte enables and lane-aligned write data.

The low two bits of the data-window byte address are ORed into the index offset. This lets 1-, 2- and 4-byte accesses reach any byte of a register. The device side answers reads combinationally in the same cycle and says whether a device is present. A read that targets an absent device, or that arrives while the enable flag is clear, returns all ones. Host read data is registered and comes back one cycle after the read strobe, together with a valid pulse.

Top module: `pci_cfg_port_dec`

## Requirements
- R1: Only host addresses 0xCF8–0xCFB (index port) and 0xCFC–0xCFF (data window) are decoded. Any other address raises no request and no read-valid.
- R2: Host write encoding: io_size 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes. A write to the index port updates the index bytes starting at lane io_addr[1:0]; lanes beyond byte 3 are dropped. The new value is visible to an access in the next cycle. An index-port read returns the stored word shifted right by 8×io_addr[1:0] and masked to the access width, without alteration.
- R3: After reset the index word is zero, io_rvalid is 0 and io_rdata is 0.
- R4: cfg_bus equals index bits 23:16 and cfg_devfn equals index bits 15:8.
- R5: cfg_reg equals index bits 7:0 ORed with the data-window address bits 1:0.
- R6: cfg_be marks the access width in bytes, starting at lane cfg_reg[1:0]; lanes above 3 are dropped.
- R7: cfg_wdata equals io_wdata shifted left by 8×cfg_reg[1:0], and cfg_we is high only for writes.
- R8: When index bit 31 is clear, data-window accesses raise no request, writes are dropped, and reads return all ones in the returned bytes.
- R9: A data-window read whose request sees cfg_hit low returns all ones in the returned bytes.
- R10: A decoded host read returns io_rvalid one cycle later. For a present device, the data is cfg_rdata shifted right by 8×cfg_reg[1:0] and masked to the access width (1 byte = 0xFF, 2 = 0xFFFF, 4 = all).
- R11: cfg_req is high only in the cycle of the host strobe, for exactly one cycle per access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 16 | Host I/O byte address |
| io_rd | input | 1 | Host read strobe, one cycle per access |
| io_wr | input | 1 | Host write strobe, one cycle per access |
| io_size | input | 2 | Access width: 0=1B, 1=2B, 2/3=4B |
| io_wdata | input | 32 | Host write data, right-justified |
| io_rdata | output | 32 | Host read data, right-justified |
| io_rvalid | output | 1 | Read data valid, one cycle after io_rd |
| cfg_req | output | 1 | Configuration request strobe |
| cfg_we | output | 1 | Request is a write |
| cfg_bus | output | 8 | Target bus number |
| cfg_devfn | output | 8 | Target device/function |
| cfg_reg | output | 8 | Byte register offset |
| cfg_be | output | 4 | Byte enables within the dword |
| cfg_wdata | output | 32 | Lane-aligned write data |
| cfg_rdata | input | 32 | Device read data, same cycle as cfg_req |
| cfg_hit | input | 1 | A device is present at the target |

## Verification
The assertions assume the host never raises io_rd and io_wr together. They also assume the device side settles cfg_hit and cfg_rdata within the request cycle. The bench drives one strobe per access at the falling edge and sets the device response from its own copy of the index word before the outputs are sampled. Device presence comes from the device number, so the stimulus reaches both present and absent targets. It also covers every offset and width, including accesses that run past byte 3.

// File: rtl/pci_cfg_port_dec.sv
module pci_cfg_port_dec #(
  parameter int          AW        = 16,
  parameter logic [15:0] IDX_PORT  = 16'h0CF8,
  parameter logic [15:0] DATA_PORT = 16'h0CFC
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] io_addr,
  input  logic          io_rd,
  input  logic          io_wr,
  input  logic [1:0]    io_size,
  input  logic [31:0]   io_wdata,
  output logic [31:0]   io_rdata,
  output logic          io_rvalid,
  output logic          cfg_req,
  output logic          cfg_we,
  output logic [7:0]    cfg_bus,
  output logic [7:0]    cfg_devfn,
  output logic [7:0]    cfg_reg,
  output logic [3:0]    cfg_be,
  output logic [31:0]   cfg_wdata,
  input  logic [31:0]   cfg_rdata,
  input  logic          cfg_hit
);

  logic [31:0] idx_q, idx_d, lane_wd, src, wmask;
  logic [3:0]  size_be, lane_be;
  logic [1:0]  off_a, off;
  logic        idx_hit, data_hit;

  assign idx_hit  = io_addr[AW-1:2] == IDX_PORT[AW-1:2];
  assign data_hit = io_addr[AW-1:2] == DATA_PORT[AW-1:2];
  assign off_a    = io_addr[1:0];

  assign size_be = (io_size == 2'd0) ? 4'b0001 :
                   (io_size == 2'd1) ? 4'b0011 : 4'b1111;
  assign wmask   = {{8{size_be[3]}}, {8{size_be[2]}}, {8{size_be[1]}}, {8{size_be[0]}}};

  assign cfg_bus   = idx_q[23:16];
  assign cfg_devfn = idx_q[15:8];
  assign cfg_reg   = {idx_q[7:2], idx_q[1:0] | off_a};
  assign off       = cfg_reg[1:0];
  assign cfg_req   = (io_rd | io_wr) & data_hit & idx_q[31];
  assign cfg_we    = cfg_req & io_wr;
  assign cfg_be    = size_be << off;
  assign cfg_wdata = io_wdata << {off, 3'b000};

  assign lane_be = size_be << off_a;
  assign lane_wd = io_wdata << {off_a, 3'b000};

  always_comb begin
    idx_d = idx_q;
    for (int i = 0; i < 4; i++)
      if (lane_be[i]) idx_d[8*i +: 8] = lane_wd[8*i +: 8];
  end

  always_comb begin
    if (idx_hit) src = idx_q >> {off_a, 3'b000};
    else         src = ((cfg_req && cfg_hit) ? cfg_rdata : 32'hFFFF_FFFF) >> {off, 3'b000};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q     <= '0;
      io_rdata  <= '0;
      io_rvalid <= 1'b0;
    end else begin
      if (io_wr && idx_hit) idx_q <= idx_d;
      io_rvalid <= io_rd & (idx_hit | data_hit);
      if (io_rd && (idx_hit || data_hit)) io_rdata <= src & wmask;
    end
  end

  p_one_op_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req |-> (io_rd ^ io_wr));
  p_req_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req && !io_rd && !io_wr |-> 1'b0) else $error("request without strobe");
  p_rvalid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    io_rvalid |-> $past(io_rd));
  p_idx_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_wr && idx_hit) |=> $stable(idx_q));
  p_disabled_ones_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && data_hit && !idx_q[31]) |=> io_rdata[7:0] == 8'hFF);
  p_absent_ones_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_req && !cfg_we && !cfg_hit) |=> io_rdata[7:0] == 8'hFF);
  p_be_low_lane_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req |-> cfg_be[off]);

endmodule

// File: tb/tb_pci_cfg_port_dec.sv
`timescale 1ns/100ps
module tb_pci_cfg_port_dec;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] io_addr = '0;
  logic io_rd = 1'b0, io_wr = 1'b0;
  logic [1:0] io_size = '0;
  logic [31:0] io_wdata = '0, cfg_rdata = '0;
  logic cfg_hit = 1'b0;
  logic [31:0] io_rdata, cfg_wdata;
  logic io_rvalid, cfg_req, cfg_we;
  logic [7:0] cfg_bus, cfg_devfn, cfg_reg;
  logic [3:0] cfg_be;
  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] idx_m = '0;

  always #2.5 clk = ~clk;

  pci_cfg_port_dec dut (.*);

  task automatic chk(input string tg, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tg, what, act, exp);
    end
  endtask

  task automatic acc(input bit rd, input bit wr, input logic [15:0] a, input logic [1:0] sz,
                     input logic [31:0] wd, input string tg);
    logic [31:0] msk, src, exp_wd;
    logic [3:0] exp_be;
    logic [7:0] creg;
    int nb, off, oa;
    bit dp, ip, ereq, hit;
    nb  = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    msk = (nb == 4) ? 32'hFFFF_FFFF : (32'h1 << (8*nb)) - 1;
    oa  = int'(a[1:0]);
    dp  = a >= 16'h0CFC && a <= 16'h0CFF;
    ip  = a >= 16'h0CF8 && a <= 16'h0CFB;
    creg = idx_m[7:0] | 8'(oa);
    off  = int'(creg[1:0]);
    ereq = idx_m[31] && dp && (rd || wr);
    hit  = idx_m[15:11] < 5'd4;
    exp_be = '0;
    for (int i = 0; i < nb; i++) if (off + i < 4) exp_be[off+i] = 1'b1;
    exp_wd = wd << (8*off);
    @(negedge clk);
    io_addr = a; io_rd = rd; io_wr = wr; io_size = sz; io_wdata = wd;
    cfg_hit = hit;
    cfg_rdata = {idx_m[23:16] ^ 8'hC0, idx_m[15:8], creg, 8'h5A};
    if (ip) src = idx_m >> (8*oa);
    else    src = ((ereq && hit) ? cfg_rdata : 32'hFFFF_FFFF) >> (8*off);
    #1;
    chk(tg, "cfg_req", {31'b0, cfg_req}, {31'b0, ereq});
    if (ereq) begin
      chk("R7", "cfg_we", {31'b0, cfg_we}, {31'b0, wr});
      chk("R4", "cfg_bus", {24'b0, cfg_bus}, {24'b0, idx_m[23:16]});
      chk("R4", "cfg_devfn", {24'b0, cfg_devfn}, {24'b0, idx_m[15:8]});
      chk("R5", "cfg_reg", {24'b0, cfg_reg}, {24'b0, creg});
      chk("R6", "cfg_be", {28'b0, cfg_be}, {28'b0, exp_be});
      if (wr) chk("R7", "cfg_wdata", cfg_wdata, exp_wd);
    end
    @(posedge clk); #1;
    io_rd = 1'b0; io_wr = 1'b0;
    chk(tg, "io_rvalid", {31'b0, io_rvalid}, {31'b0, rd && (ip || dp)});
    if (rd && (ip || dp)) chk(tg, "io_rdata", io_rdata, src & msk);
    if (wr && ip)
      for (int i = 0; i < nb; i++) if (oa + i < 4) idx_m[8*(oa+i) +: 8] = wd[8*i +: 8];
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R3", "io_rvalid", {31'b0, io_rvalid}, 32'd0);
    chk("R3", "io_rdata", io_rdata, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    acc(1, 0, 16'h0CF8, 2, 0, "R3");
    acc(0, 0, 16'h0CFC, 2, 0, "R11");
    acc(1, 0, 16'h0CFC, 2, 0, "R8");
    acc(0, 1, 16'h0CFC, 2, 32'h1234_5678, "R8");
    acc(0, 1, 16'h0CF8, 2, 32'h8012_2010, "R2");
    acc(1, 0, 16'h0CF8, 2, 0, "R2");
    acc(1, 0, 16'h0CFA, 1, 0, "R2");
    acc(1, 0, 16'h0CFB, 2, 0, "R2");
    acc(1, 0, 16'h0CFC, 2, 0, "R10");
    acc(0, 0, 16'h0CFC, 2, 0, "R11");
    acc(1, 0, 16'h0CFD, 0, 0, "R10");
    acc(1, 0, 16'h0CFE, 1, 0, "R10");
    acc(1, 0, 16'h0CFF, 2, 0, "R10");
    acc(0, 1, 16'h0CFC, 2, 32'hDEAD_BEEF, "R7");
    acc(0, 1, 16'h0CFD, 0, 32'h0000_00AB, "R7");
    acc(0, 1, 16'h0CFE, 1, 32'h0000_CAFE, "R7");
    acc(0, 1, 16'h0CFF, 2, 32'h1122_3344, "R6");
    acc(0, 1, 16'h0CF9, 0, 32'h0000_00F8, "R2");
    acc(1, 0, 16'h0CF8, 2, 0, "R2");
    acc(1, 0, 16'h0CFC, 2, 0, "R9");
    acc(1, 0, 16'h0CFE, 1, 0, "R9");
    acc(0, 1, 16'h0CF8, 0, 32'h0000_0041, "R5");
    acc(0, 1, 16'h0CF9, 0, 32'h0000_0008, "R5");
    acc(1, 0, 16'h0CFE, 0, 0, "R5");
    acc(1, 0, 16'h0CFC, 2, 0, "R5");
    acc(0, 1, 16'h0CFE, 2, 32'h5566_7788, "R6");
    acc(1, 0, 16'h0080, 2, 0, "R1");
    acc(0, 1, 16'h0CF7, 2, 32'hFFFF_FFFF, "R1");
    acc(1, 0, 16'h0D00, 2, 0, "R1");
    acc(0, 1, 16'h1CFC, 2, 32'h0BAD_0BAD, "R1");
    acc(1, 0, 16'h0CF8, 2, 0, "R1");
    acc(0, 1, 16'h0CFB, 0, 32'h0000_0000, "R8");
    acc(1, 0, 16'h0CFD, 0, 0, "R8");
    acc(0, 1, 16'h0CFC, 1, 32'h0000_9999, "R8");
    acc(1, 0, 16'h0CF8, 2, 0, "R8");
    acc(0, 0, 16'h0CF8, 2, 0, "R11");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule